// File: doc/BRIEF.md
# Control-Register Write Sequencer

This block carries out a single write into a PHY's internal control-register space. The control side-band has no free-running clock. The sequencer toggles a slow strobe clock itself and drives a select line, a 16-bit address bus, a 16-bit write-data bus with a write enable, and it watches an acknowledge input from the PHY.

A requester presents an address and a data word together with a valid pulse while the engine is idle. The engine then runs three phases:

- It sends a warm-up burst of strobe pulses with select high.
- It drops select and loads the write data with the write enable set.
- It drives the address with select and the strobe both high, then keeps pulsing the strobe until the PHY acknowledges or a retry budget runs out.

Completion is signalled with a one-cycle done pulse. A sticky timeout flag reports a write that was never acknowledged.

Top module: `cr_write_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `timeout`, `cr_clk`, `cr_sel` and `cr_wen` are all 0.
- R2: A request is taken only when `req_valid` is high while `req_ready` is high. `req_ready` stays low from the cycle after acceptance until the cycle `done` is raised. A request presented while busy is dropped: it yields no extra `done`, and it does not change the address or data of the write in flight.
- R3: Right after acceptance, `cr_sel` is high and `cr_clk` makes exactly `PRE_PULSES` (15) complete high/low pulses. `cr_sel` then falls while `cr_clk` is low.
- R4: Write data appears on `cr_wdata` with `cr_wen` = 1 while `cr_sel` is low. Only after that do the address on `cr_addr`, `cr_sel` = 1 and `cr_clk` = 1 all change in one and the same cycle. `cr_addr` changes at no other time.
- R5: Every level of `cr_clk` is held for at least `DWELL_CYC` system clock cycles before it changes again.
- R6: `cr_ack` passes through a two-flop synchronizer and is sampled once, at the end of each high phase of the acknowledge stage. If the PHY raises ack during the N-th such high phase (1 <= N <= 10), exactly N high pulses appear in that stage. The strobe then takes one final low phase, and `done` is raised with `timeout` = 0.
- R7: If no ack is seen after `MAX_TRIES` (10) attempts, exactly 10 high pulses appear in the acknowledge stage and `cr_clk` is left low. `done` is raised with `timeout` = 1.
- R8: `done` is high for exactly one cycle per write. `timeout` holds its value after `done` until the next request is accepted, and it reads 0 from the cycle after acceptance.
- R9: An ack that arrives on the last allowed attempt (the 10th) counts as success, with `timeout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request strobe |
| req_addr | input | 16 | Control-register address |
| req_data | input | 16 | Control-register write data |
| req_ready | output | 1 | Engine idle, request may be taken |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Sticky: last write was not acknowledged |
| cr_clk | output | 1 | Strobe clock to the PHY side-band |
| cr_sel | output | 1 | Side-band select |
| cr_addr | output | 16 | Side-band address bus |
| cr_wdata | output | 16 | Side-band write-data bus |
| cr_wen | output | 1 | Side-band write enable |
| cr_ack | input | 1 | Acknowledge from the PHY (asynchronous) |

## Verification
The assertions take for granted the following about the PHY's ack:

- It rises only after a strobe high edge of the acknowledge stage.
- It falls once the strobe returns low.
- It is never held high across a write boundary.

Under those conditions the done and timeout relations hold. The bench's ack model rises only on a chosen rising edge of the acknowledge stage and drops on the next falling edge. It uses a dwell long enough that the two-flop synchronizer settles before the end-of-high sample. The requester only raises a valid request with `req_ready` high, except in one deliberate test where a busy-time request is injected to show it is dropped.

// File: rtl/cr_write_seq.sv
module cr_write_seq #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int DWELL_CYC  = 100,
  parameter int PRE_PULSES = 15,
  parameter int MAX_TRIES  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              done,
  output logic              timeout,
  output logic              cr_clk,
  output logic              cr_sel,
  output logic [ADDR_W-1:0] cr_addr,
  output logic [DATA_W-1:0] cr_wdata,
  output logic              cr_wen,
  input  logic              cr_ack
);

  localparam int DW_W = $clog2(DWELL_CYC + 1);
  localparam int PC_W = $clog2(PRE_PULSES + 1);
  localparam int TR_W = $clog2(MAX_TRIES + 1);
  localparam logic [DW_W-1:0] DW_LOAD = DW_W'(DWELL_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_LOAD, S_ADDR, S_ACK_HI, S_ACK_LO, S_FIN
  } state_t;

  state_t            state;
  logic [DW_W-1:0]   dw;
  logic [PC_W-1:0]   pre_cnt;
  logic [TR_W-1:0]   tries;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              ack_m, ack_s;

  wire dwell_over = (dw == '0);

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= cr_ack;
      ack_s <= ack_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      dw       <= '0;
      pre_cnt  <= '0;
      tries    <= '0;
      a_q      <= '0;
      d_q      <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      cr_clk   <= 1'b0;
      cr_sel   <= 1'b0;
      cr_addr  <= '0;
      cr_wdata <= '0;
      cr_wen   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state != S_IDLE && !dwell_over)
        dw <= dw - DW_W'(1);
      unique case (state)
        S_IDLE: if (req_valid) begin
          a_q     <= req_addr;
          d_q     <= req_data;
          timeout <= 1'b0;
          cr_sel  <= 1'b1;
          cr_clk  <= 1'b1;
          dw      <= DW_LOAD;
          pre_cnt <= '0;
          state   <= S_PRE;
        end
        S_PRE: if (dwell_over) begin
          if (cr_clk) begin
            cr_clk <= 1'b0;
            dw     <= DW_LOAD;
          end else if (pre_cnt == PC_W'(PRE_PULSES - 1)) begin
            cr_sel <= 1'b0;
            state  <= S_LOAD;
          end else begin
            pre_cnt <= pre_cnt + PC_W'(1);
            cr_clk  <= 1'b1;
            dw      <= DW_LOAD;
          end
        end
        S_LOAD: begin
          cr_wdata <= d_q;
          cr_wen   <= 1'b1;
          state    <= S_ADDR;
        end
        S_ADDR: begin
          cr_addr <= a_q;
          cr_sel  <= 1'b1;
          cr_clk  <= 1'b1;
          dw      <= DW_LOAD;
          tries   <= '0;
          state   <= S_ACK_HI;
        end
        S_ACK_HI: if (dwell_over) begin
          cr_clk <= 1'b0;
          dw     <= DW_LOAD;
          if (ack_s) begin
            state <= S_FIN;
          end else begin
            tries <= tries + TR_W'(1);
            state <= S_ACK_LO;
          end
        end
        S_ACK_LO: if (dwell_over) begin
          if (tries == TR_W'(MAX_TRIES)) begin
            done    <= 1'b1;
            timeout <= 1'b1;
            state   <= S_IDLE;
          end else begin
            cr_clk <= 1'b1;
            dw     <= DW_LOAD;
            state  <= S_ACK_HI;
          end
        end
        S_FIN: if (dwell_over) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic            clk_d;
  logic [DW_W-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      since <= DW_W'(DWELL_CYC);
    end else begin
      clk_d <= cr_clk;
      if (cr_clk != clk_d)
        since <= '0;
      else if (since != DW_W'(DWELL_CYC))
        since <= since + DW_W'(1);
    end
  end

  assert_min_dwell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_clk != clk_d) |-> (since >= DW_W'(DWELL_CYC - 1)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_timeout_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

  assert_ready_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_sel_drop_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cr_sel) |-> !cr_clk);

  assert_wen_rise_sel_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cr_wen) |-> !cr_sel);

  assert_addr_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cr_addr) |-> ($rose(cr_clk) && cr_sel));

  assert_ends_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cr_clk);

endmodule

// File: tb/test_cr_write_seq.sv
module test_cr_write_seq;
  localparam int DW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        req_ready, done, timeout;
  logic        cr_clk, cr_sel, cr_wen;
  logic [15:0] cr_addr, cr_wdata;
  logic        cr_ack = 1'b0;

  always #5 clk = ~clk;

  cr_write_seq #(.DWELL_CYC(DW)) i_cr_write_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ready(req_ready), .done(done), .timeout(timeout),
    .cr_clk(cr_clk), .cr_sel(cr_sel), .cr_addr(cr_addr), .cr_wdata(cr_wdata),
    .cr_wen(cr_wen), .cr_ack(cr_ack)
  );

  typedef struct {
    logic [15:0] a;
    logic [15:0] d;
    int          acks;
    bit          to;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int target = 0, pushes = 0, dones = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic pclk = 1'b0, psel = 1'b0;
  bit   pre_done = 0, tog_seen = 0, seen_wen = 0, seen_sel = 0;
  int   pre_cnt = 0, ack_cnt = 0, since = 0, min_gap = 1000000;
  logic [15:0] seen_a = '0, seen_d = '0;

  always @(negedge clk) if (rst_n) begin
    if (cr_clk != pclk) begin
      if (tog_seen && since < min_gap) min_gap = since;
      tog_seen = 1;
      since = 1;
    end else since++;
    if (cr_clk && !pclk) begin
      if (!pre_done) pre_cnt++;
      else begin
        ack_cnt++;
        if (ack_cnt == 1) begin
          seen_a = cr_addr; seen_d = cr_wdata; seen_wen = cr_wen; seen_sel = cr_sel;
        end
        if (ack_cnt == target) cr_ack = 1'b1;
      end
    end
    if (!cr_clk && pclk) cr_ack = 1'b0;
    if (psel && !cr_sel) begin
      pre_done = 1;
      chk(!cr_clk, "R3", "strobe low at select drop", int'(cr_clk), 0);
    end
    if (done) begin
      dones++;
      if (q.size() == 0) chk(0, "R2", "unexpected done", dones, pushes);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(pre_cnt == 15, "R3", "warm-up pulses", pre_cnt, 15);
        chk(ack_cnt == e.acks, e.to ? "R7" : "R6", "ack-stage pulses", ack_cnt, e.acks);
        chk(seen_a == e.a, "R4", "address at first ack-stage edge", seen_a, e.a);
        chk(seen_d == e.d, "R4", "write data", seen_d, e.d);
        chk(seen_wen && seen_sel, "R4", "wen and select with address", {seen_wen, seen_sel}, 3);
        chk(timeout == e.to, (e.acks == 10 && !e.to) ? "R9" : "R7", "timeout flag", timeout, e.to);
        chk(!cr_clk, "R6", "strobe low at done", cr_clk, 0);
      end
      pre_cnt = 0; ack_cnt = 0; pre_done = 0;
    end
    pclk = cr_clk;
    psel = cr_sel;
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input int n,
                    input bit intrude);
    exp_t e;
    do @(negedge clk); while (!req_ready);
    target = n;
    e.a = a; e.d = d;
    e.to = !(n >= 1 && n <= 10);
    e.acks = e.to ? 10 : n;
    q.push_back(e);
    pushes++;
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(timeout == 1'b0, "R8", "timeout cleared on accept", timeout, 0);
    chk(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
    if (intrude) begin
      repeat (40) @(negedge clk);
      req_valid = 1'b1; req_addr = 16'hdead; req_data = 16'hbeef;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    do @(negedge clk); while (!req_ready);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done lasts one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk({done, timeout} == 2'b00, "R1", "done/timeout after reset", {done, timeout}, 0);
    chk({cr_clk, cr_sel, cr_wen} == 3'b000, "R1", "side-band idle", {cr_clk, cr_sel, cr_wen}, 0);

    wr(16'h1234, 16'habcd, 1, 0);
    wr(16'hffff, 16'h0000, 5, 0);
    wr(16'h0022, 16'h00f5, 10, 0);
    wr(16'h5a5a, 16'ha5a5, 0, 0);
    repeat (20) @(negedge clk);
    chk(timeout == 1'b1, "R8", "timeout sticky while idle", timeout, 1);
    wr(16'h0001, 16'h8000, 11, 0);
    wr(16'h8001, 16'h7ffe, 3, 1);
    chk(dones == pushes, "R2", "one done per accepted request", dones, pushes);
    chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    chk(min_gap == DW, "R5", "shortest strobe level", min_gap, DW);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule